// File: doc/BRIEF.md
# Gated-Reload Watchdog Timer

This block guards a processor against runaway software. A divide-by-twelve stage turns the system clock into machine-cycle steps, an 11-bit prescaler divides those steps further, and the prescaler's wrap advances an 8-bit up-counter. If the counter rolls past its top value, the block raises a system reset pulse of fixed length and a one-cycle strobe that clears an auxiliary control register. Then it restarts from zero.

Software holds off the reset by reloading the counter with an 8-bit start value. The time left before overflow depends on that value. A reload takes effect only if software has first armed a separate load-enable flag with its own strobe. The flag disarms itself on every successful load, so each reload needs a fresh arm. Stray writes from a confused program therefore tend to be ignored.

An active-low enable pin selects between two states. With the pin low, the watchdog counts and power-down is refused. With the pin high, counting is frozen and power-down is allowed. The processor's idle state has no influence on the watchdog.

Top module: `wdog_gated`

## Requirements
- R1: While enabled, the counter advances once every MC_DIV × 2^PRE_W clocks. After a reload with value v, the reset pulse starts exactly (2^CNT_W − v) × MC_DIV × 2^PRE_W clocks after the clock edge that samples the reload.
- R2: A reload strobe is ignored when the load-enable flag is clear. A flag that was never armed, or was cleared by reset, leaves the timing unchanged.
- R3: A successful load clears the load-enable flag, so a later reload without a new arm is ignored. If an arm strobe arrives in the same cycle as a successful load, the clear wins.
- R4: A successful load also clears the prescaler and the divide-by-twelve stage, so the first tick after a reload comes one full tick period later.
- R5: On overflow, `rst_pulse` goes high in the cycle after the overflowing edge and stays high for exactly PULSE_LEN clocks.
- R6: `aux_clr` is high for exactly one clock, in the first cycle of the reset pulse.
- R7: During the reset pulse, the counter, the prescaler and the flag are held at zero. After the pulse ends, the next overflow comes 2^CNT_W tick periods later unless a reload intervenes.
- R8: While `wd_en_n` is high, counting is frozen, no overflow can occur and `pd_allow` is 1. When the pin returns low, `pd_allow` is 0 and counting resumes from the frozen state.
- R9: The `idle` input has no effect on counting, overflow timing or the reset pulse.
- R10: While `rst_n` is low, the counter, the prescaler and the flag are cleared, and `rst_pulse` and `aux_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_en_n | input | 1 | Low enables the watchdog; high freezes it and allows power-down |
| lden_set | input | 1 | One-cycle strobe that arms the load-enable flag |
| reload | input | 1 | One-cycle reload request |
| reload_val | input | CNT_W | Start value for the counter on reload |
| idle | input | 1 | Processor idle indication (no effect on the watchdog) |
| rst_pulse | output | 1 | System reset pulse, PULSE_LEN clocks long |
| aux_clr | output | 1 | One-cycle clear strobe for the auxiliary control register |
| pd_allow | output | 1 | High when power-down is permitted |

## Verification
Some properties are checked by assertions on every cycle. After a tick, the prescaler state is zero. The prescaler and counter hold while the block is stopped. An unarmed reload leaves the counter unchanged. The flag reads clear after a load. The counter sits at zero throughout the pulse. Each overflow is followed by a pulse and a single clear strobe, and this also holds during idle.

Other behaviour only the bench's scenarios can show, because it shows up at the ports only as overflow timing. This covers the exact tick period, the count from each reload value to overflow, the pulse length, the restart after a pulse, the freeze time added by the enable pin, and reset clearing an armed flag.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DEF_MC_DIV    = 12;
    localparam int DEF_PRE_W     = 11;
    localparam int DEF_CNT_W     = 8;
    localparam int DEF_PULSE_LEN = 24;

    typedef enum logic [1:0] {
        ACT_KEEP  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } cnt_act_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int MC_DIV = wdog_pkg::DEF_MC_DIV,
    parameter int PRE_W  = wdog_pkg::DEF_PRE_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int MC_W = (MC_DIV > 1) ? $clog2(MC_DIV) : 1;
    localparam logic [MC_W-1:0] MC_LAST = MC_W'(MC_DIV - 1);

    typedef struct packed {
        logic [MC_W-1:0]  mc;
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_q, st_d;
    logic       mc_wrap;

    always_comb begin
        st_d    = st_q;
        mc_wrap = (st_q.mc == MC_LAST);
        tick_o  = run_i && mc_wrap && (&st_q.pre);
        if (clr_i) begin
            st_d = '0;
        end else if (run_i) begin
            if (mc_wrap) begin
                st_d.mc  = '0;
                st_d.pre = st_q.pre + 1'b1;
            end else begin
                st_d.mc = st_q.mc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    tick_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (st_q == '0));

    // R8
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clr_i) |=> $stable(st_q));
endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int CNT_W = wdog_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             hold_i,
    input  logic             reload_i,
    input  logic             lden_set_i,
    input  logic [CNT_W-1:0] data_i,
    output logic             load_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } cnt_state_t;

    cnt_state_t st_q, st_d;
    cnt_act_e   act;

    always_comb begin
        if (hold_i)                      act = ACT_CLEAR;
        else if (reload_i && st_q.armed) act = ACT_LOAD;
        else if (tick_i)                 act = ACT_STEP;
        else                             act = ACT_KEEP;

        load_o = (act == ACT_LOAD);
        ovf_o  = (act == ACT_STEP) && (&st_q.cnt);

        st_d = st_q;
        unique case (act)
            ACT_CLEAR: st_d = '0;
            ACT_LOAD: begin
                st_d.cnt   = data_i;
                st_d.armed = 1'b0;
            end
            ACT_STEP: begin
                st_d.cnt   = st_q.cnt + 1'b1;
                st_d.armed = st_q.armed | lden_set_i;
            end
            default: st_d.armed = st_q.armed | lden_set_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    unarmed_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && !st_q.armed && !tick_i && !hold_i) |=> $stable(st_q.cnt));

    // R3
    load_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !st_q.armed);

    // R7
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (st_q == '0));
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
    parameter int PULSE_LEN = wdog_pkg::DEF_PULSE_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    output logic pulse_o,
    output logic aux_clr_o
);
    localparam int PL_W = $clog2(PULSE_LEN + 1);
    localparam logic [PL_W-1:0] PL_INIT = PL_W'(PULSE_LEN);

    typedef struct packed {
        logic [PL_W-1:0] left;
        logic            aux;
    } pls_state_t;

    pls_state_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.aux = ovf_i;
        if (ovf_i)                 st_d.left = PL_INIT;
        else if (st_q.left != '0)  st_d.left = st_q.left - 1'b1;
        pulse_o   = (st_q.left != '0);
        aux_clr_o = st_q.aux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> (pulse_o && aux_clr_o));

    // R6
    aux_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_clr_o |=> !aux_clr_o);
endmodule

// File: rtl/wdog_gated.sv
module wdog_gated #(
    parameter int MC_DIV    = wdog_pkg::DEF_MC_DIV,
    parameter int PRE_W     = wdog_pkg::DEF_PRE_W,
    parameter int CNT_W     = wdog_pkg::DEF_CNT_W,
    parameter int PULSE_LEN = wdog_pkg::DEF_PULSE_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wd_en_n,
    input  logic             lden_set,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             idle,
    output logic             rst_pulse,
    output logic             aux_clr,
    output logic             pd_allow
);
    logic run_w, clr_w, tick_w, load_w, ovf_w;

    always_comb begin
        run_w    = !wd_en_n && !rst_pulse;
        clr_w    = rst_pulse || load_w;
        pd_allow = wd_en_n;
    end

    wdog_prescale #(.MC_DIV(MC_DIV), .PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_w),
        .clr_i  (clr_w),
        .tick_o (tick_w)
    );

    wdog_count #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_w),
        .hold_i     (rst_pulse),
        .reload_i   (reload),
        .lden_set_i (lden_set),
        .data_i     (reload_val),
        .load_o     (load_w),
        .ovf_o      (ovf_w)
    );

    wdog_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pls (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf_i     (ovf_w),
        .pulse_o   (rst_pulse),
        .aux_clr_o (aux_clr)
    );

    // R9
    idle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && ovf_w) |=> rst_pulse);

    // R8
    no_ovf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_en_n |-> !ovf_w);
endmodule

// File: tb/wdog_gated_bench.sv
module wdog_gated_bench;
    localparam int MC_DIV = 12;
    localparam int PRE_W  = 3;
    localparam int CNT_W  = 8;
    localparam int PLEN   = 24;
    localparam int PER    = MC_DIV * (1 << PRE_W);
    localparam int TOP    = 1 << CNT_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wd_en_n = 1'b0;
    logic lden_set = 1'b0;
    logic reload = 1'b0;
    logic [CNT_W-1:0] reload_val = '0;
    logic idle = 1'b0;
    logic rst_pulse, aux_clr, pd_allow;

    int nvec = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    wdog_gated #(.MC_DIV(MC_DIV), .PRE_W(PRE_W), .CNT_W(CNT_W), .PULSE_LEN(PLEN)) u_wdog_gated (
        .clk(clk), .rst_n(rst_n), .wd_en_n(wd_en_n), .lden_set(lden_set),
        .reload(reload), .reload_val(reload_val), .idle(idle),
        .rst_pulse(rst_pulse), .aux_clr(aux_clr), .pd_allow(pd_allow)
    );

    function automatic int exp_cycles(input int v, input int pause);
        return (TOP - v) * PER + pause;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // counts posedges until rst_pulse is seen high at a negedge
    task automatic run_to_ovf(input int pause_at, input int pause_len, input int stray_at,
                              input int limit, output int k);
        k = 0;
        forever begin
            @(posedge clk);
            k++;
            @(negedge clk);
            reload = 1'b0;
            if (rst_pulse) break;
            if (k > limit) break;
            idle = 1'($urandom % 2);
            if (stray_at > 0 && k == stray_at) begin
                reload     = 1'b1;
                reload_val = CNT_W'($urandom);
            end
            if (pause_len > 0 && k == pause_at) wd_en_n = 1'b1;
            if (pause_len > 0 && k == pause_at + pause_len) wd_en_n = 1'b0;
            if (pause_len > 0 && k == pause_at + 1)
                chk(pd_allow == 1'b1, "R8 pd_allow while disabled", int'(pd_allow), 1);
        end
        wd_en_n = 1'b0;
        idle    = 1'b0;
    endtask

    task automatic pulse_check();
        int width = 1;
        int auxn  = int'(aux_clr);
        chk(aux_clr == 1'b1, "R6 aux_clr in first pulse cycle", int'(aux_clr), 1);
        forever begin
            @(negedge clk);
            if (!rst_pulse) break;
            width++;
            auxn += int'(aux_clr);
            if (width > PLEN + 8) break;
        end
        chk(width == PLEN, "R5 pulse width", width, PLEN);
        chk(auxn == 1, "R6 aux_clr cycle count", auxn, 1);
    endtask

    task automatic do_reload(input int v, input bit arm_first, input bit arm_same);
        if (arm_first) begin
            lden_set = 1'b1;
            @(negedge clk);
            lden_set = 1'b0;
        end
        reload     = 1'b1;
        reload_val = CNT_W'(v);
        lden_set   = arm_same;
        @(negedge clk);
        reload   = 1'b0;
        lden_set = 1'b0;
    endtask

    task automatic run_all();
        int k, v, pa, pl, st;
        // R10 reset state
        repeat (4) @(negedge clk);
        chk(rst_pulse == 1'b0, "R10 rst_pulse in reset", int'(rst_pulse), 0);
        chk(aux_clr == 1'b0, "R10 aux_clr in reset", int'(aux_clr), 0);
        chk(pd_allow == 1'b0, "R8 pd_allow enabled", int'(pd_allow), 0);
        wd_en_n = 1'b1;
        @(negedge clk);
        chk(pd_allow == 1'b1, "R8 pd_allow disabled pin", int'(pd_allow), 1);
        wd_en_n = 1'b0;
        rst_n = 1'b1;
        // arm flag, then reset must disarm it (R10, R2)
        @(negedge clk);
        lden_set = 1'b1;
        @(negedge clk);
        lden_set = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_to_ovf(0, 0, 3, exp_cycles(0, 0) + 50, k);
        chk(k == exp_cycles(0, 0), "R2 R10 unarmed reload after reset ignored", k, exp_cycles(0, 0));
        pulse_check();
        // R7 restart from zero after pulse
        run_to_ovf(0, 0, 0, exp_cycles(0, 0) + 50, k);
        chk(k == exp_cycles(0, 0), "R7 restart after pulse", k, exp_cycles(0, 0));
        pulse_check();
        // R1 boundary: top value gives one tick
        do_reload(TOP - 1, 1'b1, 1'b0);
        run_to_ovf(0, 0, 0, exp_cycles(TOP - 1, 0) + 50, k);
        chk(k == exp_cycles(TOP - 1, 0), "R1 R4 reload top value", k, exp_cycles(TOP - 1, 0));
        pulse_check();
        // R1 boundary: zero gives full range
        do_reload(0, 1'b1, 1'b0);
        run_to_ovf(0, 0, 0, exp_cycles(0, 0) + 50, k);
        chk(k == exp_cycles(0, 0), "R1 reload zero", k, exp_cycles(0, 0));
        pulse_check();
        // R3 arm in same cycle as load: clear wins, later stray reload ignored
        v = TOP - 6;
        do_reload(v, 1'b1, 1'b1);
        run_to_ovf(0, 0, 10, exp_cycles(v, 0) + 50, k);
        chk(k == exp_cycles(v, 0), "R3 same-cycle arm loses to clear", k, exp_cycles(v, 0));
        pulse_check();
        // random reloads with pauses, idle noise, stray reloads (R1 R3 R4 R8 R9)
        for (int i = 0; i < 10; i++) begin
            v  = TOP - 16 + int'($urandom % 16);
            pa = 5 + int'($urandom % 40);
            pl = (i % 2 == 0) ? 0 : 1 + int'($urandom % 300);
            st = (i % 3 == 0) ? 0 : 2 + int'($urandom % 20);
            do_reload(v, 1'b1, 1'b0);
            run_to_ovf(pa, pl, st, exp_cycles(v, pl) + 50, k);
            chk(k == exp_cycles(v, pl), "R1 R3 R8 R9 random reload timing", k, exp_cycles(v, pl));
            pulse_check();
        end
    endtask

    initial begin
        int seed_keep;
        seed_keep = $urandom(32'h5EED_0042);
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                nvec++;
                nerr++;
                $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule